// File: doc/BRIEF.md
# Nibble-Serial Quadlet CRC-16 Engine

This block computes the 16-bit check value that protects a run of 32-bit quadlets, such as the body of a self-describing map on a serial bus. The caller pulses a start input together with the number of quadlets to cover. The quadlets are then supplied, already in bus order, through a valid/ready handshake. The block folds each quadlet into the running value four bits per clock. It begins with the top nibble of the quadlet and works down to the bottom nibble. After the last quadlet it pulses done and presents the result.

The fold is the shift-and-xor nibble form of the CCITT polynomial 0x1021, with a zero start value and most-significant-bit-first processing. The caller chooses the quadlet count; for example, a map header might cover its entry count plus two. Building the header around the result and fetching the quadlets from memory are the caller's work.

Top module: `quad_crc16`

## Requirements
- R1: After reset, in_ready_o is 0, done_o is 0 and crc_o is 0.
- R2: A start_i pulse while idle sets the running value to 0. When count_i is nonzero, crc_o reads 0 and in_ready_o is 1 on the cycle after the start.
- R3: For each nibble n, with s = (crc[15:12] xor n), the next value is ((crc << 4) xor (s << 12) xor (s << 5) xor s) truncated to 16 bits. Over a block this equals the bitwise MSB-first CRC with polynomial 0x1021 and initial value 0.
- R4: Each quadlet is folded as eight nibbles in the order bits 31:28, 27:24, and so on down to 3:0.
- R5: The 16-bit value left after one quadlet's eighth nibble is the starting value for the next quadlet of the same block.
- R6: One nibble is folded per clock. After the edge that accepts a quadlet, in_ready_o stays 0 for 8 cycles. For a quadlet that is not the last, in_ready_o returns to 1 exactly 8 clocks after that edge.
- R7: done_o is a one-cycle pulse. It rises 8 clocks after the edge that accepts the last quadlet. crc_o holds the result until the next accepted start.
- R8: A start with count_i = 0 raises done_o on the cycle after the start, with crc_o = 0.
- R9: start_i is ignored while a block is in progress. in_valid_i and in_data_i are ignored while in_ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new block (honoured only when idle) |
| count_i | input | CNT_W | Number of quadlets in the block, sampled with start_i |
| in_valid_i | input | 1 | Quadlet on in_data_i is valid |
| in_data_i | input | 32 | Quadlet, bus order |
| in_ready_o | output | 1 | Block can accept a quadlet this cycle |
| done_o | output | 1 | One-cycle pulse: crc_o holds the block result |
| crc_o | output | 16 | Running and final check value |

## Verification
A sweep drives single-quadlet blocks holding every nonzero value in every nibble position. Each of the 120 blocks has a distinct expected check value, so a swapped nibble order, a wrong fold term or a wrong shift shows up as a mismatch against the bitwise 0x1021 reference. Random multi-quadlet blocks of up to 300 quadlets, with idle gaps between handshakes, test that the value is carried correctly from one quadlet to the next. Directed cases cover a zero count, a start pulse in the middle of a fold, and valid data offered while idle; each of these is measured through the result, the done timing and in_ready_o.

// File: rtl/qcrc_pkg.sv
package qcrc_pkg;
  localparam int CRC_W = 16;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TAKE = 2'd1,
    ST_FOLD = 2'd2
  } qcrc_state_e;

  // one nibble of the shift-and-xor recurrence
  function automatic logic [CRC_W-1:0] nib_step(input logic [CRC_W-1:0] c,
                                                input logic [NIB_W-1:0] n);
    logic [NIB_W-1:0] s;
    s = c[CRC_W-1 -: NIB_W] ^ n;
    return {c[CRC_W-NIB_W-1:0], 4'h0} ^ {s, 12'h000} ^ {7'h00, s, 5'h00} ^ {12'h000, s};
  endfunction
endpackage

// File: rtl/qcrc_seq.sv
module qcrc_seq
  import qcrc_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             in_valid_i,
  output qcrc_state_e      state_o,
  output logic             ready_o,
  output logic             load_o,
  output logic             fold_o,
  output logic             clear_o,
  output logic             done_o
);
  localparam int NIBS   = DATA_W / NIB_W;
  localparam int NIB_CW = $clog2(NIBS);

  qcrc_state_e      state_q;
  logic [CNT_W-1:0] remain_q;
  logic [NIB_CW-1:0] nib_q;
  logic             done_q;
  logic             last_nib;

  assign ready_o  = (state_q == ST_TAKE);
  assign load_o   = ready_o & in_valid_i;
  assign fold_o   = (state_q == ST_FOLD);
  assign clear_o  = (state_q == ST_IDLE) & start_i;
  assign last_nib = (nib_q == NIB_CW'(NIBS - 1));
  assign state_o  = state_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      nib_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            remain_q <= count_i;
            if (count_i == '0) done_q  <= 1'b1;
            else               state_q <= ST_TAKE;
          end
        end
        ST_TAKE: begin
          if (in_valid_i) begin
            nib_q   <= '0;
            state_q <= ST_FOLD;
          end
        end
        ST_FOLD: begin
          nib_q <= nib_q + 1'b1;
          if (last_nib) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == CNT_W'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_TAKE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qcrc_shreg.sv
module qcrc_shreg
  import qcrc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NIB_W-1:0]  nib_o
);
  logic [DATA_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= data_i;
    else if (shift_i) q <= {q[DATA_W-NIB_W-1:0], {NIB_W{1'b0}}};
  end

  assign nib_o = q[DATA_W-1 -: NIB_W];
endmodule

// File: rtl/qcrc_fold.sv
module qcrc_fold
  import qcrc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clear_i) crc_q <= '0;
    else if (step_i)  crc_q <= nib_step(crc_q, nib_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/quad_crc16.sv
module quad_crc16
  import qcrc_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             in_valid_i,
  input  logic [31:0]      in_data_i,
  output logic             in_ready_o,
  output logic             done_o,
  output logic [15:0]      crc_o
);
  localparam int DATA_W = 32;

  qcrc_state_e      state;
  logic             load, fold, clear;
  logic [NIB_W-1:0] nib;

  qcrc_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .count_i    (count_i),
    .in_valid_i (in_valid_i),
    .state_o    (state),
    .ready_o    (in_ready_o),
    .load_o     (load),
    .fold_o     (fold),
    .clear_o    (clear),
    .done_o     (done_o)
  );

  qcrc_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (fold),
    .data_i  (in_data_i),
    .nib_o   (nib)
  );

  qcrc_fold u_fold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .step_i  (fold),
    .nib_i   (nib),
    .crc_o   (crc_o)
  );
endmodule

// File: rtl/qcrc_checker.sv
module qcrc_checker
  import qcrc_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] count_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             done_o,
  input logic [15:0]      crc_o,
  input qcrc_state_e      state_i
);
  logic idle;
  assign idle = (state_i == ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !start_i) |=> $stable(crc_o)); // R7

  AST_ZERO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && count_i == '0) |=> (done_o && crc_o == 16'h0000)); // R8

  AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && count_i != '0) |=> (crc_o == 16'h0000 && in_ready_o)); // R2

  AST_ACCEPT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o); // R6

  AST_FOLD_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FOLD) |-> !in_ready_o); // R6

  AST_IDLE_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> !in_ready_o); // R9

  AST_BUSY_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_TAKE) |=> !done_o); // R9
endmodule

bind quad_crc16 qcrc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .count_i    (count_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .done_o     (done_o),
  .crc_o      (crc_o),
  .state_i    (state)
);

// File: tb/test_quad_crc16.sv
`timescale 1ns/1ps
module test_quad_crc16;
  localparam int CNT_W = 10;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic             in_valid_i = 1'b0;
  logic [31:0]      in_data_i = '0;
  logic             in_ready_o, done_o;
  logic [15:0]      crc_o;

  always #2.5 clk = ~clk;

  quad_crc16 #(.CNT_W(CNT_W)) i_quad_crc16 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .count_i(count_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .done_o(done_o), .crc_o(crc_o)
  );

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  logic [31:0] blk [0:511];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h0000;
    for (int q = 0; q < n; q++)
      for (int b = 31; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ blk[q][b];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      finish_up();
    end
  end

  // run one block from blk[0..n-1]; gaps idle cycles before each quadlet
  task automatic run_block(input int n, input int gaps, input bit poke,
                           input string tag);
    logic [15:0] exp;
    exp = ref_crc(n);
    @(negedge clk); start_i = 1'b1; count_i = CNT_W'(n);
    @(negedge clk); start_i = 1'b0;
    if (n == 0) begin
      chk(done_o === 1'b1, "R8 done after zero count", 32'(done_o), 32'd1);
      chk(crc_o === 16'h0, "R8 zero result", 32'(crc_o), 32'd0);
      @(negedge clk);
      chk(done_o === 1'b0, "R7 done single pulse", 32'(done_o), 32'd0);
      return;
    end
    chk(in_ready_o === 1'b1 && crc_o === 16'h0, "R2 ready and cleared after start",
        {15'd0, in_ready_o, crc_o}, {15'd0, 1'b1, 16'h0});
    for (int q = 0; q < n; q++) begin
      int  lat;
      bit  last;
      last = (q == n - 1);
      for (int g = 0; g < gaps; g++) @(negedge clk);
      in_valid_i = 1'b1; in_data_i = blk[q];
      @(negedge clk);
      in_valid_i = 1'b0; in_data_i = $urandom;
      lat = 0;
      do begin
        chk(in_ready_o === 1'b0, "R6 stall while folding", 32'(in_ready_o), 32'd0);
        start_i = (poke && lat == 2);
        count_i = '0;
        @(posedge clk); lat++; @(negedge clk);
        start_i = 1'b0;
      end while (!(last ? done_o : in_ready_o) && lat < 40);
      chk(lat == 8, last ? "R7 done latency" : "R6 ready latency", 32'(lat), 32'd8);
      if (!last) chk(done_o === 1'b0, "R9 no early done", 32'(done_o), 32'd0);
    end
    chk(crc_o === exp, tag, 32'(crc_o), 32'(exp));
    @(negedge clk);
    chk(done_o === 1'b0 && crc_o === exp, "R7 pulse ends, result held",
        {15'd0, done_o, crc_o}, {16'd0, exp});
  endtask

  initial begin
    #12;
    chk(in_ready_o === 1'b0 && done_o === 1'b0 && crc_o === 16'h0, "R1 reset state",
        {14'd0, in_ready_o, done_o, crc_o}, 32'd0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);

    run_block(0, 0, 1'b0, "R8");

    // every nonzero value in every nibble position
    for (int p = 0; p < 8; p++)
      for (int v = 1; v < 16; v++) begin
        blk[0] = 32'(v) << (4 * p);
        run_block(1, 0, 1'b0, "R3 R4 nibble sweep result");
      end

    blk[0] = 32'hFFFF_FFFF; blk[1] = 32'h0000_0001;
    run_block(2, 0, 1'b0, "R5 carry across quadlets");

    for (int k = 1; k <= 24; k++) begin
      for (int q = 0; q < k; q++) blk[q] = $urandom;
      run_block(k, k % 3, 1'b0, "R5 random block result");
    end

    for (int q = 0; q < 300; q++) blk[q] = $urandom;
    run_block(300, 0, 1'b0, "R5 long block result");

    // start pulses mid-fold must not disturb the block
    for (int q = 0; q < 5; q++) blk[q] = $urandom;
    run_block(5, 1, 1'b1, "R9 start while busy ignored");

    // valid while idle must not be taken
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid_i = 1'b1; in_data_i = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    chk(in_ready_o === 1'b0 && done_o === 1'b0, "R9 idle ignores valid",
        {30'd0, in_ready_o, done_o}, 32'd0);
    in_valid_i = 1'b0;
    blk[0] = 32'h1234_5678; blk[1] = 32'h9ABC_DEF0;
    run_block(2, 0, 1'b0, "R9 result after idle valid");

    finish_up();
  end
endmodule